// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block sits between a memory controller's command scheduler and the column address pins of an SDRAM device. It holds a copy of the device's mode word: the burst length code, the burst ordering type and the single-write option. For every read or write command it then produces the column addresses of the whole burst, one per clock, in the order the device will use them. The controller can then tag or steer each data beat without repeating the ordering rules in several places.

A mode load strobe presents a 12-bit mode word. The word is taken only when its top bit selects the base mode register. A command presents an 8-bit starting column. From the next cycle the block drives registered column, valid and last outputs until the burst is complete. A new command issued during a burst abandons the old one at once. If the stored mode holds an illegal setting, a command raises a one-cycle error flag instead of a burst. CAS latency, data timing, banks, rows and refresh are handled elsewhere.

Top module: `burst_col_seq`

## Requirements
- R1: A mode load with word bit 11 = 0 stores length code = bits 2..0, type = bit 3 (0 sequential, 1 interleaved) and single-write = bit 9. A load with bit 11 = 1 changes nothing. Bits 6..4 (CAS latency) and the other bits have no effect on the sequence.
- R2: After reset the mode is length code 000, sequential, single-write off, and `col_valid`, `col_last` and `cfg_err` are 0.
- R3: The first access appears in the cycle after the command and equals `cmd_col`. Further accesses follow one per clock with `col_valid` high, and `col_valid` falls in the cycle after the last access unless a new command arrives.
- R4: Length code 000 gives 1 access, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives 256.
- R5: For a sequential burst of length L (2, 4 or 8), access n is the start column with its low log2(L) bits replaced by (start + n) mod L. The upper bits are unchanged.
- R6: For an interleaved burst of length L (2, 4 or 8), access n is the start column with its low log2(L) bits XORed with n.
- R7: A full-page sequential burst gives 256 accesses, (start + n) mod 256, from any start column.
- R8: With length code 000, the single access is `cmd_col` whatever the type bit is.
- R9: With single-write on, a write command (`cmd_write` = 1) gives exactly one access at `cmd_col`, and reads keep the programmed length. With single-write off, writes use the programmed length.
- R10: If the stored length code is 100, 101 or 110, or is 111 with the interleaved type, a command sets `cfg_err` high for one cycle (the cycle after the command), with `col_valid` low, and ends any burst in progress. The mode word stays stored until the next load.
- R11: A valid command during a burst replaces it: in the next cycle the output is the new start column, and the new burst runs to its full length.
- R12: `col_last` is high only on the final access of a burst.
- R13: A burst keeps the mode that was in force when its command was taken. A mode load in the same cycle as a command affects only later commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_load | input | 1 | Mode word load strobe |
| mode_word | input | 12 | Mode word |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_col | input | 8 | Starting column of the command |
| col_out | output | 8 | Registered column address of the current access |
| col_valid | output | 1 | `col_out` holds an access of an active burst |
| col_last | output | 1 | Final access of the burst |
| cfg_err | output | 1 | One-cycle pulse: the command was rejected for an illegal mode |

## Verification
The hardest situation to reach from the ports is a burst that is changed while it is running. Three cases apply: a mode load (even an illegal one) arriving mid-burst, a mode load landing in the very cycle of a command, and a new command cutting a burst short. The stimulus times the mode load and the command strobes against the observed access index. The bench checks that the current burst keeps its original shape and that only the next command sees the new settings. Around these cases, every start column is swept for every legal short length in both types, and full-page bursts run from several starts, including the wrap at column 255.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam logic [2:0] BL_ONE   = 3'b000;
  localparam logic [2:0] BL_TWO   = 3'b001;
  localparam logic [2:0] BL_FOUR  = 3'b010;
  localparam logic [2:0] BL_EIGHT = 3'b011;
  localparam logic [2:0] BL_PAGE  = 3'b111;

  // bit positions inside the mode word
  localparam int unsigned MW_LEN_LSB = 0;
  localparam int unsigned MW_TYPE    = 3;
  localparam int unsigned MW_WSINGLE = 9;
  localparam int unsigned MW_SELECT  = 11;

  typedef struct packed {
    logic [2:0] bl_code;
    logic       ilv;
    logic       wr_single;
  } mode_t;

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int unsigned MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output mode_t             mode_q
);

  mode_t mode_d;
  logic  mode_en;

  always_comb begin
    mode_en           = load && !word[MW_SELECT];
    mode_d.bl_code    = word[MW_LEN_LSB +: 3];
    mode_d.ilv        = word[MW_TYPE];
    mode_d.wr_single  = word[MW_WSINGLE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{bl_code: BL_ONE, ilv: 1'b0, wr_single: 1'b0};
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assert_select_bit_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word[MW_SELECT]) |=> $stable(mode_q));

endmodule

// File: rtl/bcs_burst_decode.sv
module bcs_burst_decode
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  mode_t            mode,
  input  logic             is_write,
  output logic [COL_W-1:0] lenm1,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             bad
);

  logic [COL_W-1:0] prog_lenm1;
  logic             prog_bad;

  always_comb begin
    prog_bad   = 1'b0;
    prog_lenm1 = '0;
    unique case (mode.bl_code)
      BL_ONE:   prog_lenm1 = '0;
      BL_TWO:   prog_lenm1 = COL_W'(1);
      BL_FOUR:  prog_lenm1 = COL_W'(3);
      BL_EIGHT: prog_lenm1 = COL_W'(7);
      BL_PAGE:  begin
        prog_lenm1 = '1;
        prog_bad   = mode.ilv;
      end
      default:  prog_bad = 1'b1;
    endcase
  end

  always_comb begin
    bad   = prog_bad;
    lenm1 = (is_write && mode.wr_single) ? '0 : prog_lenm1;
    mask  = lenm1;
    ilv   = mode.ilv && (lenm1 != '0);
  end

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] seq_val;
  logic [COL_W-1:0] ilv_val;

  always_comb begin
    seq_val = base + idx;
    ilv_val = base ^ idx;
  end

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    always_comb begin
      if (mask[g]) begin
        col[g] = ilv ? ilv_val[g] : seq_val[g];
      end else begin
        col[g] = base[g];
      end
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [COL_W-1:0]  cmd_col,
  output logic [COL_W-1:0]  col_out,
  output logic              col_valid,
  output logic              col_last,
  output logic              cfg_err
);

  localparam logic [COL_W-1:0] IDX_ONE = COL_W'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  mode_t            mode_q;
  logic [COL_W-1:0] dec_lenm1, dec_mask;
  logic             dec_ilv, dec_bad;

  bcs_mode_reg #(.MODE_W(MODE_W)) i_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (mode_load),
    .word   (mode_word),
    .mode_q (mode_q)
  );

  bcs_burst_decode #(.COL_W(COL_W)) i_dec (
    .mode     (mode_q),
    .is_write (cmd_write),
    .lenm1    (dec_lenm1),
    .mask     (dec_mask),
    .ilv      (dec_ilv),
    .bad      (dec_bad)
  );

  // burst state
  logic [COL_W-1:0] base_q, idx_q, lenm1_q, mask_q, col_q;
  logic             ilv_q, valid_q, last_q, err_q;

  logic [COL_W-1:0] base_d, idx_d, lenm1_d, mask_d, col_d;
  logic             ilv_d, valid_d, last_d, err_d;
  logic             start_en, step_en, pos_en;
  logic [COL_W-1:0] idx_step, col_step;

  assign idx_step = idx_q + IDX_ONE;

  bcs_col_gen #(.COL_W(COL_W)) i_gen (
    .base (base_q),
    .idx  (idx_step),
    .mask (mask_q),
    .ilv  (ilv_q),
    .col  (col_step)
  );

  // next-state
  always_comb begin
    start_en = cmd_valid && !dec_bad;
    step_en  = !cmd_valid && valid_q && !last_q;
    pos_en   = start_en || step_en;

    base_d  = cmd_col;
    lenm1_d = dec_lenm1;
    mask_d  = dec_mask;
    ilv_d   = dec_ilv;

    idx_d   = idx_q;
    col_d   = col_q;
    valid_d = 1'b0;
    last_d  = 1'b0;
    err_d   = cmd_valid && dec_bad;

    if (start_en) begin
      idx_d   = '0;
      col_d   = cmd_col;
      valid_d = 1'b1;
      last_d  = (dec_lenm1 == '0);
    end else if (step_en) begin
      idx_d   = idx_step;
      col_d   = col_step;
      valid_d = 1'b1;
      last_d  = (idx_step == lenm1_q);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      last_q  <= last_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q  <= '0;
      lenm1_q <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
    end else if (start_en) begin
      base_q  <= base_d;
      lenm1_q <= lenm1_d;
      mask_q  <= mask_d;
      ilv_q   <= ilv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      idx_q <= '0;
      col_q <= '0;
    end else if (pos_en) begin
      idx_q <= idx_d;
      col_q <= col_d;
    end
  end

  assign col_out   = col_q;
  assign col_valid = valid_q;
  assign col_last  = last_q;
  assign cfg_err   = err_q;

  // checks next to the sequencing logic
  assert_first_col_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && !dec_bad) |=> (col_valid && (col_out == $past(cmd_col))));

  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_last && !cmd_valid) |=> !col_valid);

  assert_block_kept_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid && !col_last && !cmd_valid)
      |=> ((col_out & ~mask_q) == ($past(col_out) & ~mask_q)));

  assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid && !col_last && !cmd_valid && !ilv_q && (mask_q == '1))
      |=> (col_out == COL_W'($past(col_out) + IDX_ONE)));

  assert_err_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_valid && dec_bad) |=> (cfg_err && !col_valid));

  assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_valid && !col_last && cmd_valid && !dec_bad) |=> (col_out == $past(cmd_col)));

  assert_last_in_burst_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    col_last |-> col_valid);

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_load;
  logic [11:0] mode_word;
  logic        cmd_valid;
  logic        cmd_write;
  logic [7:0]  cmd_col;
  logic [7:0]  col_out;
  logic        col_valid, col_last, cfg_err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq i_burst_col_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_load (mode_load),
    .mode_word (mode_word),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_col   (cmd_col),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last),
    .cfg_err   (cfg_err)
  );

  function automatic int len_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 256;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int n,
                                         input int len, input bit ilv);
    int m;
    int low;
    m = len - 1;
    if (ilv) low = (s ^ n) & m;
    else     low = (s + n) & m;
    return 8'((s & ~m) | low);
  endfunction

  task automatic chk(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic load_mode(input logic [11:0] w);
    @(negedge clk);
    mode_load = 1'b1;
    mode_word = w;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // drives a command; returns at the negedge where the first access is visible
  task automatic issue(input bit wr, input logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_col   = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // checks accesses first..len-1 starting at the current negedge, then the drop of valid
  task automatic check_stream(input logic [7:0] s, input int first, input int len,
                              input bit ilv, input string tag);
    bit ok = 1'b1;
    string msg = "";
    for (int i = first; i < len; i++) begin
      logic [7:0] e;
      bit el;
      e  = exp_col(s, i, len, ilv);
      el = (i == len - 1);
      if (ok && (!col_valid || col_out !== e || col_last !== el || cfg_err !== 1'b0)) begin
        ok  = 1'b0;
        msg = $sformatf("%s start %02h access %0d: col %02h valid %b last %b err %b, expected col %02h valid 1 last %b err 0",
                        tag, s, i, col_out, col_valid, col_last, cfg_err, e, el);
      end
      @(negedge clk);
    end
    if (ok && (col_valid !== 1'b0 || col_last !== 1'b0)) begin
      ok  = 1'b0;
      msg = $sformatf("%s start %02h after end: valid %b last %b, expected valid 0 last 0",
                      tag, s, col_valid, col_last);
    end
    chk(ok, msg);
  endtask

  task automatic burst(input bit wr, input logic [7:0] s, input int len,
                       input bit ilv, input string tag);
    issue(wr, s);
    check_stream(s, 0, len, ilv, tag);
  endtask

  task automatic err_cmd(input bit wr, input string tag);
    issue(wr, 8'h5C);
    chk(cfg_err === 1'b1 && col_valid === 1'b0,
        $sformatf("%s err cycle: err %b valid %b, expected err 1 valid 0", tag, cfg_err, col_valid));
    @(negedge clk);
    chk(cfg_err === 1'b0 && col_valid === 1'b0,
        $sformatf("%s after err: err %b valid %b, expected err 0 valid 0", tag, cfg_err, col_valid));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    mode_load = 1'b0; mode_word = '0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: outputs idle during reset
    chk(col_valid === 1'b0 && col_last === 1'b0 && cfg_err === 1'b0,
        $sformatf("R2 reset outputs: valid %b last %b err %b, expected 0 0 0", col_valid, col_last, cfg_err));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(col_valid === 1'b0 && cfg_err === 1'b0,
        $sformatf("R2 after release: valid %b err %b, expected 0 0", col_valid, cfg_err));

    // R2: reset mode is single access, burst writes
    burst(1'b0, 8'h9A, 1, 1'b0, "R2 reset read");
    burst(1'b1, 8'h9B, 1, 1'b0, "R2 reset write");

    // R1: bit 11 set -> load ignored
    load_mode(12'h803);
    burst(1'b0, 8'h40, 1, 1'b0, "R1 select bit ignored");
    // R1: CAS field does not change the length
    load_mode(12'h072);
    burst(1'b0, 8'h41, 4, 1'b0, "R1 CAS bits ignored");
    load_mode(12'h00A);
    burst(1'b0, 8'h42, 4, 1'b1, "R1 type field");

    // R4/R5/R6/R8 sweep: every start column, short lengths, both types
    for (int code = 0; code < 4; code++) begin
      for (int t = 0; t < 2; t++) begin
        load_mode(12'((t << 3) | code));
        for (int s = 0; s < 256; s++) begin
          if (code == 0)  burst(1'b0, 8'(s), 1, 1'(t), "R8 length one");
          else if (t == 0) burst(1'b0, 8'(s), len_of(code), 1'b0, "R4 R5 sequential");
          else             burst(1'b0, 8'(s), len_of(code), 1'b1, "R4 R6 interleaved");
        end
      end
    end

    // R7: full page
    load_mode(12'h007);
    burst(1'b0, 8'h00, 256, 1'b0, "R7 full page");
    burst(1'b0, 8'h37, 256, 1'b0, "R7 full page");
    burst(1'b1, 8'hFF, 256, 1'b0, "R7 full page write");

    // R9: single-write option
    load_mode(12'h203);
    burst(1'b1, 8'h33, 1, 1'b0, "R9 single write");
    burst(1'b0, 8'h33, 8, 1'b0, "R9 read keeps length");
    load_mode(12'h003);
    burst(1'b1, 8'h33, 8, 1'b0, "R9 burst write");

    // R11: restart during a burst
    issue(1'b0, 8'h00);
    for (int i = 0; i < 3; i++) begin
      chk(col_valid === 1'b1 && col_out === 8'(i) && col_last === 1'b0,
          $sformatf("R11 pre-restart access %0d: col %02h valid %b last %b, expected %02h 1 0",
                    i, col_out, col_valid, col_last, 8'(i)));
      if (i < 2) @(negedge clk);
    end
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'h45;
    @(negedge clk);
    cmd_valid = 1'b0;
    check_stream(8'h45, 0, 8, 1'b0, "R11 restart");

    // R13: mode load during a burst leaves it unchanged
    issue(1'b0, 8'h10);
    mode_load = 1'b1; mode_word = 12'h001;
    @(negedge clk);
    mode_load = 1'b0;
    check_stream(8'h10, 1, 8, 1'b0, "R13 load mid-burst");
    burst(1'b0, 8'h10, 2, 1'b0, "R13 new mode applies");
    // R13: load in the command cycle affects only later commands
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'h21;
    mode_load = 1'b1; mode_word = 12'h002;
    @(negedge clk);
    cmd_valid = 1'b0; mode_load = 1'b0;
    check_stream(8'h21, 0, 2, 1'b0, "R13 same-cycle load");
    burst(1'b0, 8'h21, 4, 1'b0, "R13 later command");

    // R10: reserved codes and full page interleaved
    load_mode(12'h004);
    err_cmd(1'b0, "R10 code 100 read");
    err_cmd(1'b1, "R10 code 100 write");
    load_mode(12'h005);
    err_cmd(1'b0, "R10 code 101");
    load_mode(12'h006);
    err_cmd(1'b0, "R10 code 110");
    load_mode(12'h00F);
    err_cmd(1'b0, "R10 full page interleaved");
    err_cmd(1'b0, "R10 mode stays stored");
    // R10: rejected command ends a burst in progress
    load_mode(12'h003);
    issue(1'b0, 8'h60);
    mode_load = 1'b1; mode_word = 12'h004;
    @(negedge clk);
    mode_load = 1'b0;
    chk(col_valid === 1'b1 && col_out === 8'h61,
        $sformatf("R10 R13 burst continues: col %02h valid %b, expected 61 1", col_out, col_valid));
    err_cmd(1'b0, "R10 err ends burst");
    load_mode(12'h003);
    burst(1'b0, 8'h66, 8, 1'b0, "R10 recovery");

    // R12 is covered by every stream check; one more short case
    load_mode(12'h001);
    burst(1'b0, 8'hFF, 2, 1'b0, "R12 last on final access");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule